// File: doc/BRIEF.md
# Ring Command-Tag Scheduler

This block is the master end of a token ring that links the DMA engines of several readout buffers. Processors in a farm ask for events by setting bits in a request bitmap, one bit per processor. The block picks the lowest-numbered pending requester. It builds a 64-bit command tag that carries the processor's identifier and the next event buffer address, then offers that tag to the ring. Every slave on the ring sees the tag, starts an identical DMA transfer toward the same processor, and bumps the tag's done counter before passing it on. When the tag comes back round to the scheduler, the block checks it against an 8-entry scoreboard.

Each launched tag takes the scoreboard entry chosen by the low three bits of its buffer address. That entry is freed when the tag returns, or when it has been outstanding for a programmed number of cycles. Error reports from the slaves arrive as message tags and are decoded beside the returns. All faults collect in a sticky error code, and a level interrupt is raised while that code is nonzero. A throttle flip-flop stops command generation. A flush input makes the block fill the ring with filler tags.

Top module: `tagsched_top`

Tag layout (bit 63 down): class [63:62], type [61:60], identifier [59:48], buffer address [47:37], done count [36:30], remaining bits [29:0] zero on transmit. Class 2'b11 with type 2'b00 is a command tag. Class 2'b10 with type 2'b11 is a slave-to-scheduler report. The all-zero word is the filler tag.

Outgoing stream rules:
- `tx_valid`/`tx_tag` describe the current offer. The offer is recomputed every cycle and may change or drop while `tx_ready` is low.
- A tag counts as sent only in a cycle where `tx_valid` and `tx_ready` are both high.

Incoming stream rules:
- `rx_ready` is tied high, so every `rx_valid` cycle delivers one tag.

## Requirements
- R1: A request bit set on `req_set` becomes pending from the next cycle. The lowest-numbered pending bit is offered. The granted bit is cleared only by a handshake of a command tag, and a new set of that same bit in the handshake cycle keeps it pending.
- R2: An offered command tag has class 2'b11, type 2'b00, the granted bit index zero-extended into bits [59:48], the current buffer address in [47:37], and zero in [36:0].
- R3: The buffer address is 0 after reset and advances by 1 modulo 2048 for each command tag sent.
- R4: Scoreboard entry i (i = buffer address bits [2:0]) is busy from the send of its tag. No command tag is offered while the entry for the current address is busy.
- R5: A returning command tag whose entry is busy frees that entry. If its done count [36:30] differs from `cfg_slaves`, or its identifier differs from the one sent, error bit 0 is set. A returning command tag whose entry is free sets error bit 2.
- R6: An entry still busy `cfg_timeout` cycles after its send is freed and sets error bit 1. A `cfg_timeout` of 0 disables expiry.
- R7: `throttle_set` sets and `throttle_clr` clears the throttle flip-flop, with set winning when both are high. While the throttle is set, no command tag is offered.
- R8: While `flush` is high, the block offers the all-zero filler tag, sends no command tag, and leaves pending requests and the buffer address unchanged.
- R9: An incoming tag of class 2'b10 and type 2'b11 sets error bit 3. Other incoming tags that are not command tags change nothing.
- R10: `err_code` bits are sticky and reset to 0. `err_clr` clears them, but errors detected in the same cycle are still recorded. `irq` is high exactly while `err_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NCPU | One-cycle request pulses, one bit per processor |
| throttle_set | input | 1 | Set the throttle flip-flop |
| throttle_clr | input | 1 | Clear the throttle flip-flop |
| flush | input | 1 | Offer filler tags while high |
| cfg_slaves | input | 7 | Expected done count of a returning command tag |
| cfg_timeout | input | TW | Return timeout in cycles, 0 disables |
| tx_valid | output | 1 | Outgoing tag offered |
| tx_ready | input | 1 | Ring accepts the outgoing tag |
| tx_tag | output | 64 | Outgoing tag |
| rx_valid | input | 1 | Incoming tag present |
| rx_ready | output | 1 | Always high |
| rx_tag | input | 64 | Incoming tag |
| err_clr | input | 1 | Clear the error code |
| err_code | output | 4 | Sticky errors: 0 mismatch, 1 timeout, 2 unexpected return, 3 slave report |
| irq | output | 1 | Error interrupt level |

## Verification
The offer on `tx_valid`/`tx_tag` depends combinationally on `flush` and on registered state. It is therefore due in the same cycle as the inputs that shape it, while a `req_set` pulse, a throttle pulse or a send takes effect on the offer one cycle later. Errors from a return, a report tag or an expiry appear in `err_code` and `irq` in the cycle after the edge at which the event was seen, and an expiry lands on the edge `cfg_timeout` cycles after the send. The bench drives inputs just after the falling edge, compares every output against a behavioural model one time unit later, and only then advances the model across the rising edge, so each result is compared in exactly the cycle it is due.

// File: rtl/tagsched_pkg.sv
package tagsched_pkg;

  localparam int TAG_W  = 64;
  localparam int ID_W   = 12;
  localparam int ADDR_W = 11;
  localparam int DONE_W = 7;
  localparam int ERR_W  = 4;

  localparam int ERR_MISMATCH = 0;
  localparam int ERR_TIMEOUT  = 1;
  localparam int ERR_UNEXP    = 2;
  localparam int ERR_SLAVE    = 3;

  typedef enum logic [1:0] {
    CLS_FILL  = 2'b00,
    CLS_FREE  = 2'b01,
    CLS_SCHED = 2'b10,
    CLS_CMD   = 2'b11
  } tag_class_e;

  typedef enum logic [1:0] {
    TY_CMD    = 2'b00,
    TY_BCAST  = 2'b01,
    TY_DIRECT = 2'b10,
    TY_REPORT = 2'b11
  } tag_type_e;

  typedef struct packed {
    logic [1:0]        cls;
    logic [1:0]        typ;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [DONE_W-1:0] done;
    logic [29:0]       rest;
  } tag_t;

  function automatic tag_t make_ctag(logic [ID_W-1:0] id, logic [ADDR_W-1:0] addr);
    tag_t t;
    t      = '0;
    t.cls  = CLS_CMD;
    t.typ  = TY_CMD;
    t.id   = id;
    t.addr = addr;
    return t;
  endfunction

endpackage

// File: rtl/tagsched_reqpick.sv
module tagsched_reqpick #(
  parameter int NCPU = 16,
  localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req_set,
  input  logic            take,
  output logic            any_req,
  output logic [IW-1:0]   gnt_idx
);

  logic [NCPU-1:0] pend_q;
  logic [NCPU-1:0] clr_mask;
  logic            found;

  // lowest index wins
  always_comb begin
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NCPU; i++) begin
      if (pend_q[i] && !found) begin
        gnt_idx = IW'(i);
        found   = 1'b1;
      end
    end
  end

  assign any_req = |pend_q;

  for (genvar g = 0; g < NCPU; g++) begin : g_clr
    assign clr_mask[g] = take && (gnt_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | req_set;
  end

  p_take_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> any_req);

  p_grant_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_set[gnt_idx]) |=> !pend_q[$past(gnt_idx)]);

endmodule

// File: rtl/tagsched_scoreboard.sv
module tagsched_scoreboard #(
  parameter int SB = 8,
  parameter int TW = 16,
  localparam int IXW = (SB > 1) ? $clog2(SB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic [IXW-1:0] launch_idx,
  input  logic [11:0]    launch_id,
  input  logic           ret_valid,
  input  logic [IXW-1:0] ret_idx,
  input  logic [11:0]    ret_id,
  input  logic [6:0]     ret_done,
  input  logic [6:0]     cfg_slaves,
  input  logic [TW-1:0]  cfg_timeout,
  output logic [SB-1:0]  busy,
  output logic           err_mismatch,
  output logic           err_unexp,
  output logic           err_timeout
);

  logic [SB-1:0] busy_q;
  logic [TW-1:0] tmr_q [SB];
  logic [11:0]   id_q  [SB];
  logic [SB-1:0] ret_hit;
  logic [SB-1:0] expire;

  for (genvar g = 0; g < SB; g++) begin : g_ent
    assign ret_hit[g] = ret_valid && busy_q[g] && (ret_idx == IXW'(g));
    assign expire[g]  = busy_q[g] && !ret_hit[g] && (cfg_timeout != '0) &&
                        (({1'b0, tmr_q[g]} + (TW+1)'(1)) == {1'b0, cfg_timeout});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < SB; i++) begin
        tmr_q[i] <= '0;
        id_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SB; i++) begin
        if (launch && (launch_idx == IXW'(i))) begin
          busy_q[i] <= 1'b1;
          tmr_q[i]  <= '0;
          id_q[i]   <= launch_id;
        end else if (ret_hit[i] || expire[i]) begin
          busy_q[i] <= 1'b0;
        end else if (busy_q[i]) begin
          tmr_q[i] <= tmr_q[i] + TW'(1);
        end
      end
    end
  end

  assign busy         = busy_q;
  assign err_unexp    = ret_valid && !busy_q[ret_idx];
  assign err_mismatch = ret_valid && busy_q[ret_idx] &&
                        ((ret_done != cfg_slaves) || (ret_id != id_q[ret_idx]));
  assign err_timeout  = |expire;

  p_launch_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_q[launch_idx]);

  p_return_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && busy_q[ret_idx] && !(launch && launch_idx == ret_idx))
      |=> !busy_q[$past(ret_idx)]);

  p_launch_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q[$past(launch_idx)]);

endmodule

// File: rtl/tagsched_top.sv
module tagsched_top
  import tagsched_pkg::*;
#(
  parameter int NCPU = 16,
  parameter int SB   = 8,
  parameter int TW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   req_set,
  input  logic              throttle_set,
  input  logic              throttle_clr,
  input  logic              flush,
  input  logic [DONE_W-1:0] cfg_slaves,
  input  logic [TW-1:0]     cfg_timeout,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [TAG_W-1:0]  tx_tag,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic              err_clr,
  output logic [ERR_W-1:0]  err_code,
  output logic              irq
);

  localparam int IW  = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int IXW = (SB > 1) ? $clog2(SB) : 1;

  logic              thr_q;
  logic [ADDR_W-1:0] buf_q;
  logic [ERR_W-1:0]  err_q;
  logic              any_req;
  logic [IW-1:0]     gnt_idx;
  logic [SB-1:0]     busy;
  logic              c_ok;
  logic              fire_c;
  tag_t              ctag;
  tag_t              rxt;
  logic              ret_valid;
  logic              slave_msg;
  logic              err_mismatch, err_unexp, err_timeout;
  logic [ERR_W-1:0]  new_err;
  logic              unused_rx;

  tagsched_reqpick #(.NCPU(NCPU)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_set (req_set),
    .take    (fire_c),
    .any_req (any_req),
    .gnt_idx (gnt_idx)
  );

  assign c_ok   = !thr_q && any_req && !busy[buf_q[IXW-1:0]];
  assign fire_c = c_ok && !flush && tx_ready;
  assign ctag   = make_ctag(ID_W'(gnt_idx), buf_q);

  assign tx_valid = flush || c_ok;
  assign tx_tag   = flush ? '0 : ctag;
  assign rx_ready = 1'b1;

  assign rxt       = rx_tag;
  assign ret_valid = rx_valid && (rxt.cls == CLS_CMD)   && (rxt.typ == TY_CMD);
  assign slave_msg = rx_valid && (rxt.cls == CLS_SCHED) && (rxt.typ == TY_REPORT);
  assign unused_rx = ^{rxt.rest, rxt.addr[ADDR_W-1:IXW]};

  tagsched_scoreboard #(.SB(SB), .TW(TW)) u_sb (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (fire_c),
    .launch_idx   (buf_q[IXW-1:0]),
    .launch_id    (ID_W'(gnt_idx)),
    .ret_valid    (ret_valid),
    .ret_idx      (rxt.addr[IXW-1:0]),
    .ret_id       (rxt.id),
    .ret_done     (rxt.done),
    .cfg_slaves   (cfg_slaves),
    .cfg_timeout  (cfg_timeout),
    .busy         (busy),
    .err_mismatch (err_mismatch),
    .err_unexp    (err_unexp),
    .err_timeout  (err_timeout)
  );

  always_comb begin
    new_err               = '0;
    new_err[ERR_MISMATCH] = err_mismatch;
    new_err[ERR_TIMEOUT]  = err_timeout;
    new_err[ERR_UNEXP]    = err_unexp;
    new_err[ERR_SLAVE]    = slave_msg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      buf_q <= '0;
      err_q <= '0;
    end else begin
      if (throttle_set)      thr_q <= 1'b1;
      else if (throttle_clr) thr_q <= 1'b0;
      if (fire_c) buf_q <= buf_q + ADDR_W'(1);
      err_q <= (err_clr ? '0 : err_q) | new_err;
    end
  end

  assign err_code = err_q;
  assign irq      = |err_q;

  p_buf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c |=> (buf_q == $past(buf_q) + ADDR_W'(1)));

  p_throttle_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q |-> !(tx_valid && tx_tag[63:62] == 2'b11));

  p_flush_filler_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (tx_valid && tx_tag == '0));

  p_flush_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(buf_q));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0 && !err_clr) |=> (err_q != '0));

  p_report_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_msg |=> irq);

endmodule

// File: tb/tb_tagsched_top.sv
module tb_tagsched_top;
  localparam int NCPU = 16;
  localparam int SB   = 8;
  localparam int TW   = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCPU-1:0] req_set;
  logic            throttle_set, throttle_clr, flush;
  logic [6:0]      cfg_slaves;
  logic [TW-1:0]   cfg_timeout;
  logic            tx_valid, tx_ready;
  logic [63:0]     tx_tag;
  logic            rx_valid, rx_ready;
  logic [63:0]     rx_tag;
  logic            err_clr;
  logic [3:0]      err_code;
  logic            irq;

  always #4 clk = ~clk;

  tagsched_top #(.NCPU(NCPU), .SB(SB), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .throttle_set(throttle_set),
    .throttle_clr(throttle_clr), .flush(flush), .cfg_slaves(cfg_slaves),
    .cfg_timeout(cfg_timeout), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_tag(tx_tag), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_tag(rx_tag),
    .err_clr(err_clr), .err_code(err_code), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R10 reset";

  bit [NCPU-1:0] m_pend;
  bit            m_thr;
  int            m_buf;
  bit [3:0]      m_err;
  bit            m_busy [SB];
  int            m_tmr  [SB];
  int            m_id   [SB];
  logic [63:0]   sent_q [$];

  function automatic logic [63:0] ref_ctag(int cpu, int addr);
    return {2'b11, 2'b00, 12'(cpu), 11'(addr), 7'd0, 30'd0};
  endfunction

  function automatic int lowest();
    for (int i = 0; i < NCPU; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic step();
    int       lo;
    bit       cok;
    bit       fire;
    bit [3:0] ne;
    bit       rh [SB];
    int       ix;
    #1;
    lo  = lowest();
    cok = !m_thr && (lo >= 0) && !m_busy[m_buf % SB];
    chk("tx_valid", 64'(tx_valid), 64'(flush || cok));
    if (flush)    chk("tx_tag filler", tx_tag, 64'd0);
    else if (cok) chk("tx_tag", tx_tag, ref_ctag(lo, m_buf));
    chk("err_code", 64'(err_code), 64'(m_err));
    chk("irq", 64'(irq), 64'(m_err != 0));
    chk("rx_ready", 64'(rx_ready), 64'd1);
    fire = cok && !flush && tx_ready;
    ne   = '0;
    for (int i = 0; i < SB; i++) rh[i] = 1'b0;
    if (rx_valid) begin
      if (rx_tag[63:62] == 2'b11 && rx_tag[61:60] == 2'b00) begin
        ix = int'(rx_tag[39:37]);
        if (m_busy[ix]) begin
          if (rx_tag[36:30] != cfg_slaves || int'(rx_tag[59:48]) != m_id[ix]) ne[0] = 1'b1;
          rh[ix] = 1'b1;
        end else ne[2] = 1'b1;
      end
      if (rx_tag[63:62] == 2'b10 && rx_tag[61:60] == 2'b11) ne[3] = 1'b1;
    end
    for (int i = 0; i < SB; i++) begin
      if (m_busy[i]) begin
        if (rh[i]) m_busy[i] = 1'b0;
        else if (cfg_timeout != 0 && m_tmr[i] + 1 == int'(cfg_timeout)) begin
          m_busy[i] = 1'b0;
          ne[1] = 1'b1;
        end else m_tmr[i]++;
      end
    end
    if (fire) begin
      ix = m_buf % SB;
      m_busy[ix] = 1'b1;
      m_tmr[ix]  = 0;
      m_id[ix]   = lo;
      sent_q.push_back(ref_ctag(lo, m_buf));
      m_pend[lo] = 1'b0;
      m_buf = (m_buf + 1) % 2048;
    end
    m_pend = m_pend | req_set;
    if (throttle_set)      m_thr = 1'b1;
    else if (throttle_clr) m_thr = 1'b0;
    m_err = (err_clr ? 4'd0 : m_err) | ne;
    @(posedge clk);
    @(negedge clk);
    req_set = '0; throttle_set = 0; throttle_clr = 0; err_clr = 0; rx_valid = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ret(int done);
    logic [63:0] t;
    if (sent_q.size() > 0) begin
      t = sent_q.pop_front();
      t[36:30] = 7'(done);
      rx_tag   = t;
      rx_valid = 1'b1;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] old;
    rst_n = 0; req_set = '0; throttle_set = 0; throttle_clr = 0; flush = 0;
    cfg_slaves = 7'd5; cfg_timeout = 16'd40; tx_ready = 1; rx_valid = 0;
    rx_tag = '0; err_clr = 0;
    m_pend = '0; m_thr = 0; m_buf = 0; m_err = '0;
    for (int i = 0; i < SB; i++) begin m_busy[i] = 0; m_tmr[i] = 0; m_id[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step();

    phase = "R1 R2 priority and format";
    req_set = 16'h088A;
    steps(6);
    phase = "R5 good return";
    for (int k = 0; k < 4; k++) begin ret(5); step(); end
    steps(2);

    phase = "R1 backpressure";
    tx_ready = 0; req_set = 16'h0200; steps(2);
    req_set = 16'h0004; steps(2);
    tx_ready = 1; steps(3);
    ret(5); step(); ret(5); step();

    phase = "R1 set wins over grant clear";
    req_set = 16'h0010; step();
    req_set = 16'h0010; step();
    steps(2);
    ret(5); step(); ret(5); step();

    phase = "R4 scoreboard full";
    req_set = 16'h03FF; steps(12);
    phase = "R6 timeout";
    steps(90);
    phase = "R10 clear";
    err_clr = 1; step(); steps(2);
    sent_q.delete();

    phase = "R7 throttle";
    throttle_set = 1; step();
    req_set = 16'h0001; steps(4);
    throttle_set = 1; throttle_clr = 1; steps(3);
    throttle_clr = 1; steps(3);
    ret(5); step();

    phase = "R8 flush";
    flush = 1; req_set = 16'h0020; steps(4);
    tx_ready = 0; step(); tx_ready = 1;
    flush = 0; steps(2);
    ret(5); step();

    phase = "R5 done mismatch";
    req_set = 16'h0040; steps(2);
    old = sent_q[0];
    ret(4); steps(2);
    phase = "R5 unexpected return";
    rx_tag = {old[63:37], 7'd5, old[29:0]}; rx_valid = 1; steps(2);
    err_clr = 1; step();
    phase = "R9 slave report";
    rx_tag = {2'b10, 2'b11, 60'h0000_0000_0123_456}; rx_valid = 1; steps(2);
    err_clr = 1; step();
    phase = "R9 ignored tags";
    rx_tag = 64'd0; rx_valid = 1; step();
    rx_tag = {2'b01, 62'd7}; rx_valid = 1; step();
    rx_tag = {2'b11, 2'b01, 60'd3}; rx_valid = 1; step();
    rx_tag = {2'b10, 2'b00, 60'd9}; rx_valid = 1; steps(2);
    phase = "R10 clear with new error";
    rx_tag = {2'b10, 2'b11, 60'd1}; rx_valid = 1; step();
    err_clr = 1; rx_tag = {2'b10, 2'b11, 60'd2}; rx_valid = 1; steps(2);
    err_clr = 1; step();

    phase = "R6 timeout disabled";
    cfg_timeout = '0; req_set = 16'h0100; steps(60);
    ret(5); step();
    cfg_timeout = 16'd40; steps(2);

    phase = "R3 address wrap";
    for (int k = 0; k < 2100; k++) begin
      req_set = NCPU'(1) << (k % NCPU);
      if (sent_q.size() > 0) ret(5);
      step();
    end
    while (sent_q.size() > 0) begin ret(5); step(); end
    steps(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule